// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a single-clock synchronous SRAM. It has a parameterised depth and a word made of byte lanes, by default two lanes of 9 bits. Every control, address and write-data input is registered on the rising clock edge. Decoding and the memory access happen on the edge after that. A read therefore returns its word one clock after the address was registered.

A burst starts when one of two active-low address strobes is accepted. One strobe is gated by the primary select. The other is always honoured. The starting address is then loaded, and a 2-bit counter supplies the other three words of the aligned group of four. The counter steps in linear or interleaved order, chosen by an order-select input. Three select inputs must agree for the block to respond. Writes go to individual lanes, or to all lanes through a global write. The output enable and the sleep input act asynchronously on the drive qualifier of the read bus. The read bus is a data vector plus a separate drive qualifier, which an outer pad ring turns into a tri-state bus.

Top module: `sburst_sram`

## Requirements
- R1: After reset no burst is open, so rd_drive stays low until a strobe selects the block.
- R2: A read presented before rising edge k has its word on rd_data, with rd_drive high, after edge k+1 and until edge k+2.
- R3: ctrl_strobe_n low is accepted whatever the other inputs are. It loads addr as the burst start when the block is selected, and it closes the burst otherwise.
- R4: proc_strobe_n low while cs_n is high is ignored. The burst address and the open or closed state are unchanged.
- R5: The block is selected only when cs_n=0, cs_hi=1 and cs2_n=0 at an accepted strobe. After any other combination no read data is driven and no write takes place until the next selecting strobe.
- R6: With order_sel=0 (linear), beat n of a burst started at address A accesses {A[AW-1:2], (A[1:0]+n) mod 4}.
- R7: With order_sel=1 (interleaved), beat n accesses {A[AW-1:2], A[1:0] xor n}.
- R8: burst_step_n low, with no accepted strobe and a burst open, moves to the next beat. After the fourth beat the sequence wraps to the first.
- R9: With no accepted strobe and burst_step_n high, the same address is accessed again. A read repeats its word.
- R10: lane_wr_n[i]=0 writes lane i, bits 9i+8..9i, of the current address. all_wr_n=0 writes every lane. A cycle that writes any lane drives no read data on the following cycle.
- R11: rd_drive is high only while out_en_n is low and sleep is low, and it follows both without waiting for a clock.
- R12: A cycle whose inputs are registered while sleep is high is ignored. Memory contents and the burst state are kept, and operation resumes with the first cycle registered after sleep falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Sleep request, high ignores new cycles and blanks the output |
| cs_n | input | 1 | Primary select, active low, also gates proc_strobe_n |
| cs_hi | input | 1 | Second select, active high |
| cs2_n | input | 1 | Third select, active low |
| proc_strobe_n | input | 1 | Processor-side address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller-side address strobe, active low |
| burst_step_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | AW | Word address |
| wdata | input | LANES*LANE_W | Write data |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| all_wr_n | input | 1 | Global write, active low, writes all lanes |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| rd_data | output | LANES*LANE_W | Read data |
| rd_drive | output | 1 | High when rd_data is to be driven onto the bus |

## Verification
Inputs change on the falling edge. A cycle's read word and its drive qualifier are due at the second falling edge after those inputs were applied, because one edge registers the inputs and the next one accesses the array. The bench keeps a one-deep queue of expected results from its own model. At each falling edge it compares the result of the stimulus applied two falling edges earlier. The asynchronous gating of rd_drive is applied using the out_en_n and sleep values present at the comparison instant. Writes, ignored strobes and sleep cycles are checked by reading the affected addresses back later and comparing against the model.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  localparam int unsigned BURST_CNT_W = 2;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burst_order_e;

  // Low address bits for a given beat of a burst.
  function automatic logic [BURST_CNT_W-1:0] burst_low(
    input logic [BURST_CNT_W-1:0] start,
    input logic [BURST_CNT_W-1:0] beat,
    input burst_order_e           order
  );
    if (order == ORDER_INTERLEAVE) return start ^ beat;
    else                           return start + beat;
  endfunction

endpackage

// File: rtl/sbs_input_reg.sv
module sbs_input_reg #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 18,
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep,
  input  logic             cs_n,
  input  logic             cs_hi,
  input  logic             cs2_n,
  input  logic             proc_strobe_n,
  input  logic             ctrl_strobe_n,
  input  logic             burst_step_n,
  input  logic             order_sel,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             all_wr_n,
  output logic             v_q,
  output logic             cs_n_q,
  output logic             cs_hi_q,
  output logic             cs2_n_q,
  output logic             proc_strobe_n_q,
  output logic             ctrl_strobe_n_q,
  output logic             burst_step_n_q,
  output logic             order_sel_q,
  output logic [AW-1:0]    addr_q,
  output logic [DW-1:0]    wdata_q,
  output logic [LANES-1:0] lane_wr_n_q,
  output logic             all_wr_n_q
);

  logic v_d;

  always_comb begin
    v_d = ~sleep;
  end

  // Control captures carry reset; address and data are plain flops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q             <= 1'b0;
      cs_n_q          <= 1'b1;
      cs_hi_q         <= 1'b0;
      cs2_n_q         <= 1'b1;
      proc_strobe_n_q <= 1'b1;
      ctrl_strobe_n_q <= 1'b1;
      burst_step_n_q  <= 1'b1;
      order_sel_q     <= 1'b0;
      lane_wr_n_q     <= '1;
      all_wr_n_q      <= 1'b1;
    end else begin
      v_q             <= v_d;
      cs_n_q          <= cs_n;
      cs_hi_q         <= cs_hi;
      cs2_n_q         <= cs2_n;
      proc_strobe_n_q <= proc_strobe_n;
      ctrl_strobe_n_q <= ctrl_strobe_n;
      burst_step_n_q  <= burst_step_n;
      order_sel_q     <= order_sel;
      lane_wr_n_q     <= lane_wr_n;
      all_wr_n_q      <= all_wr_n;
    end
  end

  always_ff @(posedge clk) begin
    addr_q  <= addr;
    wdata_q <= wdata;
  end

  // R12: a cycle registered during sleep is marked void
  a_r12_sleep_voids_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !v_q);

endmodule

// File: rtl/sbs_burst_ctrl.sv
module sbs_burst_ctrl
  import sbs_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          v,
  input  logic          cs_n,
  input  logic          cs_hi,
  input  logic          cs2_n,
  input  logic          proc_strobe_n,
  input  logic          ctrl_strobe_n,
  input  logic          burst_step_n,
  input  logic          order_sel,
  input  logic [AW-1:0] addr,
  output logic          op_active,
  output logic [AW-1:0] op_addr
);

  localparam int unsigned CW = BURST_CNT_W;

  logic          open_q, open_d;
  logic [AW-1:0] base_q, base_d;
  logic [CW-1:0] beat_q, beat_d;
  logic          strobe, selected;

  always_comb begin
    strobe   = ~ctrl_strobe_n | (~proc_strobe_n & ~cs_n);
    selected = ~cs_n & cs_hi & ~cs2_n;
    open_d   = open_q;
    base_d   = base_q;
    beat_d   = beat_q;
    if (v) begin
      if (strobe) begin
        open_d = selected;
        if (selected) begin
          base_d = addr;
          beat_d = '0;
        end
      end else if (!burst_step_n && open_q) begin
        beat_d = beat_q + 1'b1;
      end
    end
    op_active = v & open_d;
    op_addr   = {base_d[AW-1:CW],
                 burst_low(base_d[CW-1:0], beat_d, burst_order_e'(order_sel))};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
    end else if (v) begin
      open_q <= open_d;
      base_q <= base_d;
      beat_q <= beat_d;
    end
  end

  // R8: an advance steps the beat by one and keeps the base
  a_r8_advance_step: assert property (@(posedge clk) disable iff (!rst_n)
    (v && ctrl_strobe_n && !(!proc_strobe_n && !cs_n) && !burst_step_n && open_q)
    |=> (beat_q == $past(beat_q) + 2'd1) && $stable(base_q));

  // R9: no strobe and no advance keeps the whole burst state
  a_r9_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
    (v && ctrl_strobe_n && !(!proc_strobe_n && !cs_n) && burst_step_n)
    |=> $stable(beat_q) && $stable(base_q) && $stable(open_q));

  // R4: processor strobe with primary select high changes nothing
  a_r4_proc_strobe_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (v && !proc_strobe_n && cs_n && ctrl_strobe_n && burst_step_n)
    |=> $stable(base_q) && $stable(open_q));

  // R5: an accepted strobe without full selection closes the burst
  a_r5_deselect_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (v && !ctrl_strobe_n && !(!cs_n && cs_hi && !cs2_n)) |=> !open_q);

endmodule

// File: rtl/sbs_mem_array.sv
module sbs_mem_array #(
  parameter int unsigned AW = 8,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           op_addr,
  input  logic [LANES-1:0]        lane_we,
  input  logic                    rd_en,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata_q,
  output logic                    rvalid_q
);

  localparam int unsigned DEPTH = 1 << AW;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cells_q [DEPTH];
      always_ff @(posedge clk) begin
        if (lane_we[g]) cells_q[op_addr] <= wdata[g*LANE_W +: LANE_W];
        if (rd_en)      rdata_q[g*LANE_W +: LANE_W] <= cells_q[op_addr];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= rd_en;
  end

endmodule

// File: rtl/sburst_sram.sv
module sburst_sram #(
  parameter int unsigned AW = 8,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sleep,
  input  logic                    cs_n,
  input  logic                    cs_hi,
  input  logic                    cs2_n,
  input  logic                    proc_strobe_n,
  input  logic                    ctrl_strobe_n,
  input  logic                    burst_step_n,
  input  logic                    order_sel,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    all_wr_n,
  input  logic                    out_en_n,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_drive
);

  localparam int unsigned DW = LANES * LANE_W;

  logic             v_q, cs_n_q, cs_hi_q, cs2_n_q;
  logic             proc_strobe_n_q, ctrl_strobe_n_q, burst_step_n_q, order_sel_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [LANES-1:0] lane_wr_n_q;
  logic             all_wr_n_q;
  logic             op_active;
  logic [AW-1:0]    op_addr;
  logic [LANES-1:0] lane_we;
  logic             rd_en;
  logic             rvalid_q;

  sbs_input_reg #(.AW(AW), .DW(DW), .LANES(LANES)) u_inreg (
    .clk            (clk),
    .rst_n          (rst_n),
    .sleep          (sleep),
    .cs_n           (cs_n),
    .cs_hi          (cs_hi),
    .cs2_n          (cs2_n),
    .proc_strobe_n  (proc_strobe_n),
    .ctrl_strobe_n  (ctrl_strobe_n),
    .burst_step_n   (burst_step_n),
    .order_sel      (order_sel),
    .addr           (addr),
    .wdata          (wdata),
    .lane_wr_n      (lane_wr_n),
    .all_wr_n       (all_wr_n),
    .v_q            (v_q),
    .cs_n_q         (cs_n_q),
    .cs_hi_q        (cs_hi_q),
    .cs2_n_q        (cs2_n_q),
    .proc_strobe_n_q(proc_strobe_n_q),
    .ctrl_strobe_n_q(ctrl_strobe_n_q),
    .burst_step_n_q (burst_step_n_q),
    .order_sel_q    (order_sel_q),
    .addr_q         (addr_q),
    .wdata_q        (wdata_q),
    .lane_wr_n_q    (lane_wr_n_q),
    .all_wr_n_q     (all_wr_n_q)
  );

  sbs_burst_ctrl #(.AW(AW)) u_burst (
    .clk          (clk),
    .rst_n        (rst_n),
    .v            (v_q),
    .cs_n         (cs_n_q),
    .cs_hi        (cs_hi_q),
    .cs2_n        (cs2_n_q),
    .proc_strobe_n(proc_strobe_n_q),
    .ctrl_strobe_n(ctrl_strobe_n_q),
    .burst_step_n (burst_step_n_q),
    .order_sel    (order_sel_q),
    .addr         (addr_q),
    .op_active    (op_active),
    .op_addr      (op_addr)
  );

  // Global write overrides the per-lane enables.
  always_comb begin
    if (!op_active)      lane_we = '0;
    else if (!all_wr_n_q) lane_we = '1;
    else                 lane_we = ~lane_wr_n_q;
    rd_en = op_active & ~(|lane_we);
  end

  sbs_mem_array #(.AW(AW), .LANE_W(LANE_W), .LANES(LANES)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_addr (op_addr),
    .lane_we (lane_we),
    .rd_en   (rd_en),
    .wdata   (wdata_q),
    .rdata_q (rd_data),
    .rvalid_q(rvalid_q)
  );

  always_comb begin
    rd_drive = rvalid_q & ~out_en_n & ~sleep;
  end

  // R10: a write cycle leaves no read word behind it
  a_r10_write_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_we) |=> !rvalid_q);

  // R11: the bus is never driven with the output enable high
  a_r11_drive_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drive |-> !out_en_n && !sleep);

  // R5: no lane write without an open burst
  a_r5_no_write_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    !op_active |-> lane_we == '0);

endmodule

// File: tb/sburst_sram_bench.sv
module sburst_sram_bench;
  localparam int AW = 8;
  localparam int LW = 9;
  localparam int NL = 2;
  localparam int DW = NL * LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          sleep, cs_n, cs_hi, cs2_n;
  logic          proc_strobe_n, ctrl_strobe_n, burst_step_n, order_sel;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [NL-1:0] lane_wr_n;
  logic          all_wr_n, out_en_n;
  logic [DW-1:0] rd_data;
  logic          rd_drive;

  sburst_sram #(.AW(AW), .LANE_W(LW), .LANES(NL)) u_sburst_sram (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .cs_n(cs_n), .cs_hi(cs_hi),
    .cs2_n(cs2_n), .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
    .burst_step_n(burst_step_n), .order_sel(order_sel), .addr(addr),
    .wdata(wdata), .lane_wr_n(lane_wr_n), .all_wr_n(all_wr_n),
    .out_en_n(out_en_n), .rd_data(rd_data), .rd_drive(rd_drive)
  );

  int checks = 0;
  int fails = 0;

  // Reference model state
  logic [DW-1:0] mm [DEPTH];
  bit            m_open;
  logic [AW-1:0] m_base;
  logic [1:0]    m_beat;

  bit            p_has;
  bit            p_valid;
  logic [DW-1:0] p_data;
  string         p_tag;

  function automatic logic [DW-1:0] pattern(input int n);
    return DW'((n * 1237) ^ 18'h2A5A5);
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_exec(output bit ev, output logic [DW-1:0] ed);
    bit         strobe;
    logic [1:0] low, lanes;
    logic [AW-1:0] op;
    ev = 1'b0;
    ed = '0;
    if (!sleep) begin
      strobe = !ctrl_strobe_n || (!proc_strobe_n && !cs_n);
      if (strobe) begin
        if (!cs_n && cs_hi && !cs2_n) begin
          m_open = 1'b1; m_base = addr; m_beat = 2'd0;
        end else m_open = 1'b0;
      end else if (!burst_step_n && m_open) m_beat = m_beat + 2'd1;
      if (m_open) begin
        low   = order_sel ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
        op    = {m_base[AW-1:2], low};
        lanes = !all_wr_n ? 2'b11 : ~lane_wr_n;
        if (lanes != 2'b00) begin
          if (lanes[0]) mm[op][LW-1:0]  = wdata[LW-1:0];
          if (lanes[1]) mm[op][DW-1:LW] = wdata[DW-1:LW];
        end else begin
          ev = 1'b1;
          ed = mm[op];
        end
      end
    end
  endtask

  // Inputs are already applied at this falling edge; result is due two falling edges later.
  task automatic cyc(input string tag);
    bit ev;
    logic [DW-1:0] ed;
    bit exp_drive;
    model_exec(ev, ed);
    @(negedge clk);
    if (p_has) begin
      exp_drive = p_valid && !out_en_n && !sleep;
      chk({p_tag, " rd_drive"}, DW'(rd_drive), DW'(exp_drive));
      if (exp_drive) chk({p_tag, " rd_data"}, rd_data, p_data);
    end
    p_has = 1'b1; p_valid = ev; p_data = ed; p_tag = tag;
  endtask

  task automatic idle();
    sleep = 0; cs_n = 0; cs_hi = 1; cs2_n = 0;
    proc_strobe_n = 1; ctrl_strobe_n = 1; burst_step_n = 1;
    lane_wr_n = '1; all_wr_n = 1; out_en_n = 0;
  endtask

  task automatic do_summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    do_summary();
    $finish;
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'd20240611);
    idle();
    order_sel = 0; addr = '0; wdata = '0;
    m_open = 0; m_base = '0; m_beat = '0; p_has = 0; p_valid = 0; p_data = '0; p_tag = "";
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 drive in reset", DW'(rd_drive), '0);
    rst_n = 1;
    // R1: reads without any strobe produce nothing
    for (int i = 0; i < 3; i++) cyc("R1 idle after reset");

    // Fill every word with a linear burst of global writes
    for (int b = 0; b < DEPTH / 4; b++) begin
      for (int k = 0; k < 4; k++) begin
        idle();
        all_wr_n = 0;
        wdata = pattern(b * 4 + k);
        if (k == 0) begin ctrl_strobe_n = 0; addr = AW'(b * 4); end
        else burst_step_n = 0;
        cyc("R10 global fill");
      end
    end

    // R6 linear burst from low bits 01, then wrap (R8)
    idle(); ctrl_strobe_n = 0; addr = 8'h05; order_sel = 0; cyc("R6 linear beat0");
    for (int k = 1; k < 5; k++) begin idle(); burst_step_n = 0; cyc("R6 R8 linear step"); end
    // R7 interleaved burst from low bits 10
    idle(); order_sel = 1; proc_strobe_n = 0; addr = 8'h3A; cyc("R7 interleave beat0");
    for (int k = 1; k < 5; k++) begin idle(); burst_step_n = 0; cyc("R7 R8 interleave step"); end
    // R9 hold repeats
    for (int k = 0; k < 3; k++) begin idle(); cyc("R9 hold repeat"); end
    // R4 processor strobe ignored with cs_n high
    idle(); cs_n = 1; proc_strobe_n = 0; addr = 8'h80; cyc("R4 ignored strobe");
    idle(); cyc("R4 burst kept");
    idle(); burst_step_n = 0; cyc("R4 step after ignored");
    // R3 controller strobe with cs_n high closes burst
    idle(); cs_n = 1; ctrl_strobe_n = 0; addr = 8'h40; cyc("R3 ctrl strobe deselect");
    idle(); cyc("R3 R5 closed read");
    idle(); all_wr_n = 0; wdata = 18'h3FFFF; cyc("R5 closed write");
    idle(); ctrl_strobe_n = 0; addr = 8'h40; order_sel = 0; cyc("R3 ctrl strobe load");
    // R5 third and second selects
    idle(); ctrl_strobe_n = 0; cs2_n = 1; addr = 8'h44; cyc("R5 cs2_n high");
    idle(); cyc("R5 closed");
    idle(); ctrl_strobe_n = 0; cs_hi = 0; addr = 8'h44; cyc("R5 cs_hi low");
    idle(); ctrl_strobe_n = 0; addr = 8'h44; cyc("R5 reselect");
    // R10 per-lane writes
    idle(); lane_wr_n = 2'b10; wdata = 18'h15555; cyc("R10 lane0 write");
    idle(); cyc("R10 lane0 readback");
    idle(); lane_wr_n = 2'b01; wdata = 18'h2AAAA; cyc("R10 lane1 write");
    idle(); cyc("R10 lane1 readback");
    // R11 output enable gating
    idle(); out_en_n = 1; cyc("R11 oe high");
    idle(); cyc("R11 oe low again");
    // R12 sleep ignores a write strobe
    idle(); sleep = 1; ctrl_strobe_n = 0; all_wr_n = 0; addr = 8'h44; wdata = 18'h00001; cyc("R12 sleep write");
    idle(); sleep = 1; cyc("R12 sleep hold");
    idle(); cyc("R12 resume read");
    idle(); cyc("R12 contents kept");

    // Constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      r = $urandom();
      idle();
      addr = AW'($urandom());
      wdata = DW'($urandom());
      order_sel = r[0];
      ctrl_strobe_n = !(r[3:1] == 3'd0);
      proc_strobe_n = !(r[6:4] == 3'd0);
      burst_step_n = r[7];
      if (r[10:8] == 3'd0) begin
        lane_wr_n = r[12:11];
        all_wr_n = r[13];
      end
      if (r[16:14] == 3'd0) cs_n = 1;
      if (r[19:17] == 3'd0) cs_hi = 0;
      if (r[22:20] == 3'd0) cs2_n = 1;
      out_en_n = (r[25:23] == 3'd0);
      sleep = (r[29:26] == 4'd0);
      cyc("R2 R6 R7 R9 random");
    end
    idle(); cyc("R2 drain");
    idle(); cyc("R2 drain");
    do_summary();
    $finish;
  end

endmodule